// File: doc/BRIEF.md
# Bus Clock-Enable Prescaler with Timer Rate Selection

This block lives entirely in one fast system clock domain and derives no clocks. It issues single-cycle enable strobes instead. The high-speed bus strobe is the system clock divided by a power of two. A fast and a slow peripheral bus strobe are each the high-speed strobe divided by a further power of two. Logic in each domain runs on the system clock and advances only in cycles where its strobe is high.

Each peripheral domain also has a timer strobe. Its rate depends on the domain's divide factor and on one timer-multiplier mode bit. The timer strobe is one of three things: a copy of the high-speed strobe, twice the peripheral rate, or four times the peripheral rate. A last strobe, for a system tick counter, runs at a fixed fraction of the high-speed rate.

Every strobe is produced by counting. Each counter counts the strobe of the level above it, so all strobes share their edges with the ones they derive from. A new divide setting, or a new mode value, is taken up only when the affected counter finishes its current period.

Top module: `bus_strobe_gen`

## Requirements
- R1: While `rst_n` is low, every strobe output is 0. Reset selects divide 1 for every domain and clears the mode bit. In the first cycles after release, `hclk_en`, both peripheral strobes and both timer strobes are 1 in every cycle.
- R2: `ahb_div_sel` picks the high-speed divide factor D. Codes 0 to 7 select 1. Codes 8, 9, 10, 11, 12, 13, 14 and 15 select 2, 4, 8, 16, 64, 128, 256 and 512. `hclk_en` pulses once every D system clock cycles.
- R3: `apbf_div_sel` and `apbs_div_sel` each pick a peripheral divide factor F. Codes 0 to 3 select 1. Codes 4, 5, 6 and 7 select 2, 4, 8 and 16. The matching peripheral strobe pulses once every F pulses of `hclk_en`.
- R4: The peripheral strobes and the timer strobes are high only in cycles where `hclk_en` is also high.
- R5: With `tim_mul_mode` = 0 and F = 1, the domain's timer strobe equals `hclk_en`.
- R6: With `tim_mul_mode` = 0 and F > 1, the timer strobe pulses twice per peripheral strobe period.
- R7: With `tim_mul_mode` = 1 and F of 1 or 2, the timer strobe equals `hclk_en`.
- R8: With `tim_mul_mode` = 1 and F of 4 or more, the timer strobe pulses four times per peripheral strobe period.
- R9: In every cycle where a peripheral strobe is high, that domain's timer strobe is also high.
- R10: `tick_en` pulses once every TICK_DIV pulses of `hclk_en`. The default TICK_DIV is 8.
- R11: A divide or mode change takes effect only at the end of the affected counter's current period. When D changes, the interval between pulses in progress is finished at the old length, and the intervals after it use the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ahb_div_sel | input | 4 | High-speed bus divide code |
| apbf_div_sel | input | 3 | Fast peripheral bus divide code |
| apbs_div_sel | input | 3 | Slow peripheral bus divide code |
| tim_mul_mode | input | 1 | Timer multiplier mode: 0 selects the twice rule, 1 selects the four-times rule |
| hclk_en | output | 1 | High-speed bus enable strobe |
| pclk_fast_en | output | 1 | Fast peripheral bus enable strobe |
| pclk_slow_en | output | 1 | Slow peripheral bus enable strobe |
| tim_fast_en | output | 1 | Timer enable strobe for the fast peripheral domain |
| tim_slow_en | output | 1 | Timer enable strobe for the slow peripheral domain |
| tick_en | output | 1 | System tick enable strobe |

## Verification
Some properties are checked by assertions in every cycle. Every derived strobe must coincide with `hclk_en`. Each peripheral strobe must carry its timer strobe with it. The tick strobe must be spaced by exactly TICK_DIV high-speed pulses. Strobe rates are a different matter, because they hold only over whole periods. They are checked by the bench, which counts the pulses on each output over a window after every setting change. This covers the rate of each domain, the timer multiplier rules in both modes, and the boundary-aligned uptake of a new divide factor.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
   localparam int AHB_SEL_W = 4;
   localparam int APB_SEL_W = 3;
   localparam int AHB_SH_W  = 4;
   localparam int APB_SH_W  = 3;
   localparam int AHB_CNT_W = 9;
   localparam int APB_CNT_W = 4;
   localparam int N_APB     = 2;

   // High-speed bus code to log2 of divide factor (16 is followed by 64)
   function automatic logic [AHB_SH_W-1:0] ahb_shift(input logic [AHB_SEL_W-1:0] sel);
      logic [AHB_SH_W-1:0] low;
      low = {1'b0, sel[2:0]};
      if (!sel[3])
         return '0;
      else if (sel[2:0] < 3'd4)
         return low + 4'd1;
      else
         return low + 4'd2;
   endfunction

   // Peripheral bus code to log2 of divide factor
   function automatic logic [APB_SH_W-1:0] apb_shift(input logic [APB_SEL_W-1:0] sel);
      if (!sel[2])
         return '0;
      else
         return {1'b0, sel[1:0]} + 3'd1;
   endfunction
endpackage

// File: rtl/bsg_div_stage.sv
module bsg_div_stage #(
   parameter int CW = 4,
   parameter int SW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic [SW-1:0] nxt_shift,
   output logic          hit,
   output logic [CW-1:0] cnt_q,
   output logic [SW-1:0] act_q
);
   localparam logic [CW-1:0] ONES = {CW{1'b1}};

   if (CW < 1) begin : g_bad_cw
      $error("bsg_div_stage: CW must be at least 1");
   end
   if ((2 ** SW) - 1 < CW) begin : g_bad_sw
      $error("bsg_div_stage: SW too narrow for CW");
   end

   logic [CW-1:0] lim;

   always_comb begin
      lim = ~(ONES << act_q);
      hit = adv && (cnt_q == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= '0;
      end else if (adv) begin
         if (hit) begin
            cnt_q <= '0;
            act_q <= nxt_shift;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bsg_timer_tap.sv
module bsg_timer_tap #(
   parameter int CW = 4,
   parameter int SW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          bnd,
   input  logic          mode_in,
   input  logic [CW-1:0] apb_cnt,
   input  logic [SW-1:0] apb_act,
   output logic          hit
);
   localparam logic [CW-1:0] ONES = {CW{1'b1}};

   if (CW < 2) begin : g_bad_cw
      $error("bsg_timer_tap: CW must be at least 2");
   end

   logic          mode_q;
   logic [SW-1:0] sub;
   logic [SW-1:0] tsh;
   logic [CW-1:0] mask;

   always_comb begin
      sub  = mode_q ? SW'(2) : SW'(1);
      tsh  = (apb_act > sub) ? (apb_act - sub) : '0;
      mask = ~(ONES << tsh);
      hit  = adv && ((apb_cnt & mask) == mask);
   end

   // mode is taken up only at the peripheral period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_q <= 1'b0;
      else if (bnd)
         mode_q <= mode_in;
   end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
   import bsg_pkg::*;
#(
   parameter int TICK_DIV = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AHB_SEL_W-1:0] ahb_div_sel,
   input  logic [APB_SEL_W-1:0] apbf_div_sel,
   input  logic [APB_SEL_W-1:0] apbs_div_sel,
   input  logic                 tim_mul_mode,
   output logic                 hclk_en,
   output logic                 pclk_fast_en,
   output logic                 pclk_slow_en,
   output logic                 tim_fast_en,
   output logic                 tim_slow_en,
   output logic                 tick_en
);
   localparam int TICK_SH   = $clog2(TICK_DIV);
   localparam int TICK_CW   = (TICK_SH < 1) ? 1 : TICK_SH;
   localparam int TICK_SW   = $clog2(TICK_CW + 1) + 1;
   localparam int N_STROBES = 2 + 2 * N_APB;

   if (TICK_DIV < 2 || (1 << TICK_SH) != TICK_DIV) begin : g_bad_tick
      $error("bus_strobe_gen: TICK_DIV must be a power of two of at least 2");
   end

   logic                 ahb_hit;
   logic [AHB_CNT_W-1:0] ahb_cnt;
   logic [AHB_SH_W-1:0]  ahb_act;

   bsg_div_stage #(.CW(AHB_CNT_W), .SW(AHB_SH_W)) u_ahb (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (1'b1),
      .nxt_shift(ahb_shift(ahb_div_sel)),
      .hit      (ahb_hit),
      .cnt_q    (ahb_cnt),
      .act_q    (ahb_act)
   );

   logic [APB_SEL_W-1:0] apb_sel [N_APB];
   logic [N_APB-1:0]     apb_hit;
   logic [N_APB-1:0]     tim_hit;

   assign apb_sel[0] = apbf_div_sel;
   assign apb_sel[1] = apbs_div_sel;

   for (genvar d = 0; d < N_APB; d++) begin : g_apb
      logic [APB_CNT_W-1:0] cnt;
      logic [APB_SH_W-1:0]  act;

      bsg_div_stage #(.CW(APB_CNT_W), .SW(APB_SH_W)) u_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .adv      (ahb_hit),
         .nxt_shift(apb_shift(apb_sel[d])),
         .hit      (apb_hit[d]),
         .cnt_q    (cnt),
         .act_q    (act)
      );

      bsg_timer_tap #(.CW(APB_CNT_W), .SW(APB_SH_W)) u_tim (
         .clk    (clk),
         .rst_n  (rst_n),
         .adv    (ahb_hit),
         .bnd    (apb_hit[d]),
         .mode_in(tim_mul_mode),
         .apb_cnt(cnt),
         .apb_act(act),
         .hit    (tim_hit[d])
      );
   end

   logic               tick_hit;
   logic [TICK_CW-1:0] tick_cnt;
   logic [TICK_SW-1:0] tick_act;

   bsg_div_stage #(.CW(TICK_CW), .SW(TICK_SW)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (ahb_hit),
      .nxt_shift(TICK_SW'(TICK_SH)),
      .hit      (tick_hit),
      .cnt_q    (tick_cnt),
      .act_q    (tick_act)
   );

   // one register stage for all strobes keeps them mutually aligned
   logic [N_STROBES-1:0] strb_d, strb_q;

   assign strb_d = {tick_hit, tim_hit, apb_hit, ahb_hit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         strb_q <= '0;
      else
         strb_q <= strb_d;
   end

   assign hclk_en      = strb_q[0];
   assign pclk_fast_en = strb_q[1];
   assign pclk_slow_en = strb_q[2];
   assign tim_fast_en  = strb_q[3];
   assign tim_slow_en  = strb_q[4];
   assign tick_en      = strb_q[5];
endmodule

// File: rtl/bsg_checker.sv
module bsg_checker #(
   parameter int TICK_DIV = 8
) (
   input logic clk,
   input logic rst_n,
   input logic hclk_en,
   input logic pclk_fast_en,
   input logic pclk_slow_en,
   input logic tim_fast_en,
   input logic tim_slow_en,
   input logic tick_en
);
   localparam int GW = $clog2(TICK_DIV) + 2;

   logic [GW-1:0] gap_q;
   logic          seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (tick_en) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else if (hclk_en) begin
         gap_q  <= gap_q + 1'b1;
      end
   end

   AST_PF_WITH_H: assert property (@(posedge clk) disable iff (!rst_n) pclk_fast_en |-> hclk_en); // R4
   AST_PS_WITH_H: assert property (@(posedge clk) disable iff (!rst_n) pclk_slow_en |-> hclk_en); // R4
   AST_TF_WITH_H: assert property (@(posedge clk) disable iff (!rst_n) tim_fast_en |-> hclk_en); // R4
   AST_TS_WITH_H: assert property (@(posedge clk) disable iff (!rst_n) tim_slow_en |-> hclk_en); // R4
   AST_PF_HAS_TIM: assert property (@(posedge clk) disable iff (!rst_n) pclk_fast_en |-> tim_fast_en); // R9
   AST_PS_HAS_TIM: assert property (@(posedge clk) disable iff (!rst_n) pclk_slow_en |-> tim_slow_en); // R9
   AST_TICK_WITH_H: assert property (@(posedge clk) disable iff (!rst_n) tick_en |-> hclk_en); // R10
   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && seen_q) |-> (gap_q == GW'(TICK_DIV - 1))); // R10
endmodule

bind bus_strobe_gen bsg_checker #(.TICK_DIV(TICK_DIV)) u_chk (.*);

// File: tb/tb_bus_strobe_gen.sv
module tb_bus_strobe_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ahb_div_sel = '0;
   logic [2:0] apbf_div_sel = '0;
   logic [2:0] apbs_div_sel = '0;
   logic       tim_mul_mode = 1'b0;
   logic       hclk_en, pclk_fast_en, pclk_slow_en, tim_fast_en, tim_slow_en, tick_en;

   int n_chk = 0;
   int n_fail = 0;
   int n_done = 0;

   typedef struct {
      int win;
      int h, pf, ps, tf, ts, tk;
      string tag;
   } exp_t;

   exp_t sb_q[$];

   always #4 clk = ~clk;

   bus_strobe_gen dut (
      .clk(clk), .rst_n(rst_n),
      .ahb_div_sel(ahb_div_sel), .apbf_div_sel(apbf_div_sel), .apbs_div_sel(apbs_div_sel),
      .tim_mul_mode(tim_mul_mode),
      .hclk_en(hclk_en), .pclk_fast_en(pclk_fast_en), .pclk_slow_en(pclk_slow_en),
      .tim_fast_en(tim_fast_en), .tim_slow_en(tim_slow_en), .tick_en(tick_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int ahb_fac(input int i);
      return (i <= 4) ? (1 << i) : (1 << (i + 1));
   endfunction
   function automatic logic [3:0] ahb_code(input int i);
      return (i == 0) ? 4'd0 : 4'(7 + i);
   endfunction
   function automatic logic [2:0] apb_code(input int j);
      return (j == 0) ? 3'd0 : 3'(3 + j);
   endfunction
   function automatic int tim_cnt(input int w, input int d, input int f, input bit m);
      if (!m) return (f == 1) ? w / d : 2 * w / (d * f);   // R5 R6
      else    return (f <= 2) ? w / d : 4 * w / (d * f);   // R7 R8
   endfunction

   // monitor: pops an expected item, counts strobes over its window, compares
   initial begin
      forever begin
         exp_t e;
         int ch, cpf, cps, ctf, cts, ctk;
         wait (sb_q.size() > 0);
         e = sb_q.pop_front();
         ch = 0; cpf = 0; cps = 0; ctf = 0; cts = 0; ctk = 0;
         repeat (e.win) begin
            @(negedge clk);
            ch  += int'(hclk_en);
            cpf += int'(pclk_fast_en);
            cps += int'(pclk_slow_en);
            ctf += int'(tim_fast_en);
            cts += int'(tim_slow_en);
            ctk += int'(tick_en);
         end
         chk(ch == e.h, {"R2 hclk rate ", e.tag}, ch, e.h);
         chk(cpf == e.pf, {"R3 fast pclk rate ", e.tag}, cpf, e.pf);
         chk(cps == e.ps, {"R3 slow pclk rate ", e.tag}, cps, e.ps);
         chk(ctf == e.tf, {"R5-8 fast timer rate (R6/R8) ", e.tag}, ctf, e.tf);
         chk(cts == e.ts, {"R5-8 slow timer rate (R5/R7) ", e.tag}, cts, e.ts);
         chk(ctk == e.tk, {"R10 tick rate ", e.tag}, ctk, e.tk);
         n_done++;
      end
   end

   // driver: apply a setting, let old periods drain, push expectation
   task automatic run_cfg(input int i, input int jf, input int js, input bit m, input int d_old);
      exp_t e;
      int d, ff, fs;
      d  = ahb_fac(i);
      ff = 1 << jf;
      fs = 1 << js;
      @(negedge clk);
      ahb_div_sel  = ahb_code(i);
      apbf_div_sel = apb_code(jf);
      apbs_div_sel = apb_code(js);
      tim_mul_mode = m;
      repeat (16 * (d_old + d) + 32) @(negedge clk);
      e.win = 16 * d;
      e.h   = e.win / d;
      e.pf  = e.win / (d * ff);
      e.ps  = e.win / (d * fs);
      e.tf  = tim_cnt(e.win, d, ff, m);
      e.ts  = tim_cnt(e.win, d, fs, m);
      e.tk  = e.win / (d * 8);
      e.tag = $sformatf("D=%0d Ff=%0d Fs=%0d mode=%0d", d, ff, fs, m);
      sb_q.push_back(e);
      wait (n_done == n_done + 0 && sb_q.size() == 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int target;
      int d_prev;
      // R1: quiet during reset
      repeat (3) @(negedge clk);
      chk({hclk_en, pclk_fast_en, pclk_slow_en, tim_fast_en, tim_slow_en, tick_en} == 6'd0,
          "R1 outputs in reset", int'({hclk_en, pclk_fast_en, pclk_slow_en, tim_fast_en, tim_slow_en, tick_en}), 0);
      rst_n = 1'b1;
      // R1: divide 1 everywhere after release
      repeat (4) begin
         @(negedge clk);
         chk({hclk_en, pclk_fast_en, pclk_slow_en, tim_fast_en, tim_slow_en} == 5'h1f,
             "R1 default divide 1", int'({hclk_en, pclk_fast_en, pclk_slow_en, tim_fast_en, tim_slow_en}), 31);
      end

      // rate sweep through the scoreboard
      target = 0;
      d_prev = 1;
      for (int i = 0; i < 9; i++) begin
         int ncomb;
         ncomb = (i <= 4) ? 10 : 1;
         for (int c = 0; c < ncomb; c++) begin
            int jf, js;
            bit m;
            if (i <= 4) begin
               m  = c[0];
               jf = (c / 2) % 5;
               js = (jf + 2) % 5;
            end else begin
               m  = i[0];
               jf = i % 5;
               js = (i + 3) % 5;
            end
            run_cfg(i, jf, js, m, d_prev);
            target++;
            wait (n_done == target);
            d_prev = ahb_fac(i);
         end
      end

      // R11: change divide mid-period; running interval keeps its old length
      begin
         int g1, g2;
         @(negedge clk);
         ahb_div_sel = 4'd9;                  // divide 4
         repeat (80 + 16 * 512) @(negedge clk);
         while (!hclk_en) @(negedge clk);
         ahb_div_sel = 4'd8;                  // divide 2, requested right after a pulse
         g1 = 0;
         do begin @(negedge clk); g1++; end while (!hclk_en);
         g2 = 0;
         do begin @(negedge clk); g2++; end while (!hclk_en);
         chk(g1 == 4, "R11 interval in progress keeps old length", g1, 4);
         chk(g2 == 2, "R11 next interval uses new length", g2, 2);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule